// File: doc/BRIEF.md
# Dual-Mode ADC Conversion Autosequencer

This block runs lists of analog-to-digital conversions on an external 10-bit converter without processor involvement. A table of sixteen slots, each holding a 4-bit channel number, describes what to convert. Each time a start trigger arrives, the block works through a run of slots. For every slot it opens an acquisition window of programmable length and then asks the converter for a result through a request/done handshake. Each returned code is stored in the result register whose index matches the slot.

The slot table can serve two independent sequencers or one long one. In split mode, sequencer A owns slots 0 to 7 and sequencer B owns slots 8 to 15, and each has its own triggers. In cascaded mode, sequencer A alone walks all sixteen slots. Each sequencer can raise its interrupt on every end of sequence or only on every second one. In stop mode a sequencer pauses after its run and continues from the following slot on the next trigger, so that conversions line up with separately timed triggers.

Top module: `adc_autoseq`

## Requirements
- R1: After reset, `conv_req`, `conv_acq`, `irq_a`, `irq_b` and `busy` are low, and every result register reads 0.
- R2: Before every conversion request, `conv_acq` is high for exactly `acq_len`+1 cycles. `conv_acq` and `conv_req` are never high together.
- R3: In split mode (`cascade_en`=0), a one-cycle pulse on `sw_go_a`, `evt_trig_a` or `ext_trig` starts sequencer A. The run starts at A's slot pointer. Slot s converts the channel in `slot_chan[4s+3:4s]` and writes its code to result register s, which is read back on `rd_data` when `rd_addr`=s.
- R4: In split mode, `sw_go_b` or `evt_trig_b` starts sequencer B. B's pointer p selects slot and result register 8+p. These two triggers never start sequencer A.
- R5: A run performs `last_slot_x`+1 conversions. In split mode, only the low 3 bits of `last_slot_x` are used, so a value of 12 gives 5 conversions.
- R6: In cascaded mode (`cascade_en`=1), all five triggers start sequencer A, which wraps its pointer at 16 instead of 8. The end-of-sequence interrupt appears only on `irq_a`, and `irq_b` stays low.
- R7: If both sequencers are waiting to start, A runs first. A trigger that arrives while a run is in progress is held and served once the engine is idle.
- R8: With `alt_irq_x`=1, the first end of sequence after reset raises no interrupt, the second does, and the pattern alternates from there. With `alt_irq_x`=0, every end of sequence raises one.
- R9: With `stop_mode_x`=1, the pointer is left on the slot after the last converted one, wrapping at the slot limit. With `stop_mode_x`=0, it returns to 0 at the end of every run.
- R10: A pulse on `ptr_clr_x` while that sequencer is not running sets its pointer to 0.
- R11: `conv_req` stays high with a steady `conv_chan` until `conv_done`. The code on `conv_code` in that cycle is the one that gets stored.
- R12: The interrupt is a one-cycle pulse in the cycle after the `conv_done` of the run's final conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cascade_en | input | 1 | 1: one 16-slot sequencer; 0: two 8-slot sequencers |
| slot_chan | input | 64 | Channel table, slot s in bits [4s+3:4s] |
| last_slot_a | input | 4 | Conversions per run of A, minus one |
| last_slot_b | input | 4 | Conversions per run of B, minus one |
| stop_mode_a | input | 1 | A keeps its pointer between runs |
| stop_mode_b | input | 1 | B keeps its pointer between runs |
| alt_irq_a | input | 1 | A interrupts on every second end of sequence |
| alt_irq_b | input | 1 | B interrupts on every second end of sequence |
| ptr_clr_a | input | 1 | Return A's pointer to slot 0 |
| ptr_clr_b | input | 1 | Return B's pointer to slot 0 |
| sw_go_a | input | 1 | Software start for A |
| sw_go_b | input | 1 | Software start for B |
| evt_trig_a | input | 1 | Event trigger for A |
| evt_trig_b | input | 1 | Event trigger for B |
| ext_trig | input | 1 | External start pin (A) |
| acq_len | input | 4 | Acquisition window length minus one, in cycles |
| conv_acq | output | 1 | Acquisition window open |
| conv_req | output | 1 | Conversion request |
| conv_chan | output | 4 | Channel for the current slot |
| conv_done | input | 1 | Converter has the result ready |
| conv_code | input | 10 | Converter result |
| rd_addr | input | 4 | Result register select |
| rd_data | output | 10 | Selected result register |
| irq_a | output | 1 | End-of-sequence interrupt, A |
| irq_b | output | 1 | End-of-sequence interrupt, B |
| busy | output | 1 | A run is in progress or a start is waiting |

## Verification
The bench fires both event triggers in the same cycle. A design with the wrong priority would convert slot 8 before slot 0. It also re-triggers A while A is running; a design that drops that trigger would show two conversions instead of four. Stop mode is run across the 8-slot wrap and then through a pointer clear. Errors here show up as a run that restarts at 0, runs past slot 7 into B's slots, or ignores the clear. The remaining runs use a count of 12 in split mode, which must give 5 conversions and not 13 or 8. They also cover alternate interrupts, where a missing toggle would fire on the first end of sequence, and a 16-slot cascaded run started from B's event input, which must convert slots 0 to 15 without ever raising `irq_b`.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACQ  = 2'd1,
      ST_CONV = 2'd2
   } eng_state_e;

   localparam int NUM_SEQ = 2;
endpackage

// File: rtl/adc_trig_latch.sv
module adc_trig_latch #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);
   if (N < 1) begin : g_bad_n
      $error("adc_trig_latch: N must be at least 1");
   end

   // a fresh trigger in the same cycle as a grant stays latched
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o <= '0;
      else        pend_o <= set_i | (pend_o & ~clr_i);
   end
endmodule

// File: rtl/adc_acq_timer.sv
module adc_acq_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] len_i,
   output logic         expired_o
);
   if (W < 1) begin : g_bad_w
      $error("adc_acq_timer: W must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load_i)       cnt_q <= len_i;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 10,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [AW-1:0]     waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [AW-1:0]     raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("adc_result_bank: DEPTH must be a power of two of at least 2");
   end

   logic [DATA_W-1:0] view [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              q <= '0;
         else if (we_i && waddr_i == AW'(g))      q <= wdata_i;
      end
      assign view[g] = q;
   end

   assign rdata_o = view[raddr_i];
endmodule

// File: rtl/adc_autoseq.sv
module adc_autoseq
   import adc_seq_pkg::*;
#(
   parameter int DATA_W = 10,
   parameter int CHAN_W = 4,
   parameter int SLOTS  = 16,
   parameter int ACQ_W  = 4,
   localparam int PTR_W = $clog2(SLOTS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cascade_en,
   input  logic [SLOTS*CHAN_W-1:0] slot_chan,
   input  logic [PTR_W-1:0]        last_slot_a,
   input  logic [PTR_W-1:0]        last_slot_b,
   input  logic                    stop_mode_a,
   input  logic                    stop_mode_b,
   input  logic                    alt_irq_a,
   input  logic                    alt_irq_b,
   input  logic                    ptr_clr_a,
   input  logic                    ptr_clr_b,
   input  logic                    sw_go_a,
   input  logic                    sw_go_b,
   input  logic                    evt_trig_a,
   input  logic                    evt_trig_b,
   input  logic                    ext_trig,
   input  logic [ACQ_W-1:0]        acq_len,
   output logic                    conv_acq,
   output logic                    conv_req,
   output logic [CHAN_W-1:0]       conv_chan,
   input  logic                    conv_done,
   input  logic [DATA_W-1:0]       conv_code,
   input  logic [PTR_W-1:0]        rd_addr,
   output logic [DATA_W-1:0]       rd_data,
   output logic                    irq_a,
   output logic                    irq_b,
   output logic                    busy
);
   localparam int HALF_W = PTR_W - 1;
   localparam logic [PTR_W-1:0] FULL_LAST = PTR_W'(SLOTS - 1);
   localparam logic [PTR_W-1:0] HALF_LAST = PTR_W'(SLOTS / 2 - 1);

   if (SLOTS < 4 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("adc_autoseq: SLOTS must be a power of two of at least 4");
   end
   if (CHAN_W < 1 || DATA_W < 1 || ACQ_W < 1) begin : g_bad_width
      $error("adc_autoseq: widths must be positive");
   end

   // channel table unpacked per slot
   logic [CHAN_W-1:0] chan_tab [SLOTS];
   for (genvar s = 0; s < SLOTS; s++) begin : g_chan
      assign chan_tab[s] = slot_chan[s*CHAN_W +: CHAN_W];
   end

   eng_state_e state_q;
   logic       act_q;
   logic [PTR_W-1:0] cnt_q;
   logic [PTR_W-1:0] ptr_q [NUM_SEQ];
   logic [PTR_W-1:0] last_cfg [NUM_SEQ];
   logic [NUM_SEQ-1:0] par_q, irq_q, pend, trig, take;
   logic [NUM_SEQ-1:0] stop_mode, alt_irq, ptr_clr;
   logic start_a, start_b;

   assign stop_mode   = {stop_mode_b, stop_mode_a};
   assign alt_irq     = {alt_irq_b, alt_irq_a};
   assign ptr_clr     = {ptr_clr_b, ptr_clr_a};
   assign last_cfg[0] = last_slot_a;
   assign last_cfg[1] = last_slot_b;

   // trigger routing: cascaded mode folds B's sources onto A
   assign trig[0] = sw_go_a | evt_trig_a | ext_trig
                  | (cascade_en & (sw_go_b | evt_trig_b));
   assign trig[1] = ~cascade_en & (sw_go_b | evt_trig_b);

   assign start_a = (state_q == ST_IDLE) & pend[0];
   assign start_b = (state_q == ST_IDLE) & ~pend[0] & pend[1] & ~cascade_en;
   assign take[0] = start_a;
   assign take[1] = start_b | cascade_en;

   adc_trig_latch #(.N(NUM_SEQ)) u_trig (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (trig),
      .clr_i  (take),
      .pend_o (pend)
   );

   // active-slot arithmetic
   logic [PTR_W-1:0] cur_ptr, abs_slot, nxt_ptr, slot_last, sess_last;
   logic             final_conv, done_hit, acq_load, acq_expired;

   always_comb begin
      cur_ptr   = ptr_q[act_q];
      slot_last = cascade_en ? FULL_LAST : HALF_LAST;
      sess_last = cascade_en ? last_cfg[act_q] : (last_cfg[act_q] & HALF_LAST);
      abs_slot  = act_q ? {1'b1, cur_ptr[HALF_W-1:0]} : cur_ptr;
      nxt_ptr   = (cur_ptr == slot_last) ? '0 : cur_ptr + 1'b1;
   end

   assign final_conv = (cnt_q == sess_last);
   assign done_hit   = (state_q == ST_CONV) & conv_done;
   assign acq_load   = start_a | start_b | (done_hit & ~final_conv);

   adc_acq_timer #(.W(ACQ_W)) u_acq (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (acq_load),
      .len_i     (acq_len),
      .expired_o (acq_expired)
   );

   // conversion engine
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         act_q   <= 1'b0;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_a || start_b) begin
                  act_q   <= start_b;
                  cnt_q   <= '0;
                  state_q <= ST_ACQ;
               end
            end
            ST_ACQ: begin
               if (acq_expired) state_q <= ST_CONV;
            end
            ST_CONV: begin
               if (conv_done) begin
                  if (final_conv) state_q <= ST_IDLE;
                  else begin
                     cnt_q   <= cnt_q + 1'b1;
                     state_q <= ST_ACQ;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // per-sequencer pointer, interrupt parity and interrupt pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_SEQ; i++) ptr_q[i] <= '0;
         par_q <= '0;
         irq_q <= '0;
      end else begin
         for (int i = 0; i < NUM_SEQ; i++) begin
            if (done_hit && act_q == 1'(i)) begin
               ptr_q[i] <= (final_conv && !stop_mode[i]) ? '0 : nxt_ptr;
            end else if (ptr_clr[i] && !(state_q != ST_IDLE && act_q == 1'(i))) begin
               ptr_q[i] <= '0;
            end
            irq_q[i] <= done_hit && final_conv && act_q == 1'(i)
                        && (!alt_irq[i] || par_q[i]);
            if (done_hit && final_conv && act_q == 1'(i) && alt_irq[i])
               par_q[i] <= ~par_q[i];
         end
      end
   end

   adc_result_bank #(.DEPTH(SLOTS), .DATA_W(DATA_W)) u_res (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (done_hit),
      .waddr_i (abs_slot),
      .wdata_i (conv_code),
      .raddr_i (rd_addr),
      .rdata_o (rd_data)
   );

   assign conv_acq  = (state_q == ST_ACQ);
   assign conv_req  = (state_q == ST_CONV);
   assign conv_chan = chan_tab[abs_slot];
   assign irq_a     = irq_q[0];
   assign irq_b     = irq_q[1];
   assign busy      = (state_q != ST_IDLE) | (|pend);
endmodule

// File: rtl/adc_autoseq_chk.sv
module adc_autoseq_chk #(
   parameter int CHAN_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cascade_en,
   input logic              conv_acq,
   input logic              conv_req,
   input logic [CHAN_W-1:0] conv_chan,
   input logic              conv_done,
   input logic              irq_a,
   input logic              irq_b,
   input logic              busy
);
   assert_acq_req_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(conv_acq && conv_req));

   assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && !conv_done) |=> (conv_req && $stable(conv_chan)));

   assert_irq_a_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      irq_a |=> !irq_a);

   assert_irq_b_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      irq_b |=> !irq_b);

   assert_irq_after_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_a || irq_b) |-> $past(conv_done));

   assert_irq_b_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_b |-> $past(!cascade_en));

   assert_busy_on_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req || conv_acq) |-> busy);
endmodule

bind adc_autoseq adc_autoseq_chk #(.CHAN_W(CHAN_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cascade_en (cascade_en),
   .conv_acq   (conv_acq),
   .conv_req   (conv_req),
   .conv_chan  (conv_chan),
   .conv_done  (conv_done),
   .irq_a      (irq_a),
   .irq_b      (irq_b),
   .busy       (busy)
);

// File: tb/tb_adc_autoseq.sv
module tb_adc_autoseq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cascade_en = 1'b0;
   logic [63:0] slot_chan;
   logic [3:0] last_slot_a = '0, last_slot_b = '0;
   logic stop_mode_a = 0, stop_mode_b = 0, alt_irq_a = 0, alt_irq_b = 0;
   logic ptr_clr_a = 0, ptr_clr_b = 0;
   logic sw_go_a = 0, sw_go_b = 0, evt_trig_a = 0, evt_trig_b = 0, ext_trig = 0;
   logic [3:0] acq_len = 4'd2;
   logic conv_acq, conv_req, conv_done, irq_a, irq_b, busy;
   logic [3:0] conv_chan;
   logic [9:0] conv_code;
   logic [3:0] rd_addr = '0;
   logic [9:0] rd_data;

   int total = 0, bad = 0;
   int irq_a_cnt = 0, irq_b_cnt = 0;
   int log_n = 0, conv_n = 0, req_wait = 0, acq_run = 0, exp_acq = 3;
   int log_chan [64];
   int log_data [64];
   bit finished = 0;

   always #2 clk = ~clk;

   adc_autoseq dut (
      .clk(clk), .rst_n(rst_n), .cascade_en(cascade_en), .slot_chan(slot_chan),
      .last_slot_a(last_slot_a), .last_slot_b(last_slot_b),
      .stop_mode_a(stop_mode_a), .stop_mode_b(stop_mode_b),
      .alt_irq_a(alt_irq_a), .alt_irq_b(alt_irq_b),
      .ptr_clr_a(ptr_clr_a), .ptr_clr_b(ptr_clr_b),
      .sw_go_a(sw_go_a), .sw_go_b(sw_go_b), .evt_trig_a(evt_trig_a),
      .evt_trig_b(evt_trig_b), .ext_trig(ext_trig), .acq_len(acq_len),
      .conv_acq(conv_acq), .conv_req(conv_req), .conv_chan(conv_chan),
      .conv_done(conv_done), .conv_code(conv_code), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq_a(irq_a), .irq_b(irq_b), .busy(busy)
   );

   function automatic int chan_of(int s);
      return (s * 7 + 3) % 16;
   endfunction

   task automatic check(string req, int got, int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s got=%0d exp=%0d", req, got, exp);
      end
   endtask

   always @(negedge clk) begin
      if (irq_a) irq_a_cnt++;
      if (irq_b) irq_b_cnt++;
   end

   // converter model: answers two cycles into each request
   initial begin
      conv_done = 0;
      conv_code = '0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (conv_done) conv_done = 0;
            else if (conv_req) begin
               if (req_wait == 0) begin
                  check("R2 acq window", acq_run, exp_acq);
                  acq_run = 0;
               end
               req_wait++;
               if (req_wait == 2) begin
                  req_wait = 0;
                  conv_code = 10'((conv_n * 97 + int'(conv_chan) * 5 + 3) % 1024);
                  if (log_n < 64) begin
                     log_chan[log_n] = int'(conv_chan);
                     log_data[log_n] = int'(conv_code);
                     log_n++;
                  end
                  conv_n++;
                  conv_done = 1;
               end
            end
            if (conv_acq) acq_run++;
         end
      end
   end

   task automatic read_reg(int a, output int v);
      @(negedge clk);
      rd_addr = 4'(a);
      #1 v = int'(rd_data);
   endtask

   task automatic wait_idle();
      repeat (2) @(negedge clk);
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   // 0 sw A, 1 sw B, 2 evt A, 3 evt B, 4 ext, 5 both events
   task automatic fire(int sel);
      @(negedge clk);
      case (sel)
         0: sw_go_a = 1;
         1: sw_go_b = 1;
         2: evt_trig_a = 1;
         3: evt_trig_b = 1;
         4: ext_trig = 1;
         default: begin evt_trig_a = 1; evt_trig_b = 1; end
      endcase
      @(negedge clk);
      {sw_go_a, sw_go_b, evt_trig_a, evt_trig_b, ext_trig} = '0;
   endtask

   task automatic check_sess(int ls, int p0, int cnt, int lim, int base, bit regs, string req);
      int v;
      for (int k = 0; k < cnt; k++) begin
         int slot = base + (p0 + k) % lim;
         check(req, log_chan[ls + k], chan_of(slot));
         if (regs) begin
            read_reg(slot, v);
            check(req, v, log_data[ls + k]);
         end
      end
   endtask

   task automatic t_reset();
      int v;
      check("R1 conv_req", int'(conv_req), 0);
      check("R1 conv_acq", int'(conv_acq), 0);
      check("R1 irq", int'(irq_a | irq_b), 0);
      check("R1 busy", int'(busy), 0);
      read_reg(0, v);  check("R1 reg0", v, 0);
      read_reg(15, v); check("R1 reg15", v, 0);
   endtask

   task automatic t_dual_a();
      int ia = irq_a_cnt;
      log_n = 0; last_slot_a = 4'd3;
      fire(0); wait_idle();
      check("R3 count", log_n, 4);
      check_sess(0, 0, 4, 8, 0, 1, "R3 slots");
      check("R12 irq_a once", irq_a_cnt - ia, 1);
      check("R3 irq_b silent", irq_b_cnt, 0);
   endtask

   task automatic t_dual_b();
      int ib = irq_b_cnt;
      int ia = irq_a_cnt;
      log_n = 0; last_slot_b = 4'd2;
      fire(3); wait_idle();
      check("R4 count", log_n, 3);
      check_sess(0, 0, 3, 8, 8, 1, "R4 slots");
      check("R4 irq_b", irq_b_cnt - ib, 1);
      check("R4 irq_a unchanged", irq_a_cnt - ia, 0);
   endtask

   task automatic t_both();
      log_n = 0; last_slot_a = 4'd1; last_slot_b = 4'd1;
      fire(5); wait_idle();
      check("R7 count", log_n, 4);
      check_sess(0, 0, 2, 8, 0, 1, "R7 A first");
      check_sess(2, 0, 2, 8, 8, 1, "R7 B second");
   endtask

   task automatic t_latched();
      int ia = irq_a_cnt;
      log_n = 0; last_slot_a = 4'd1;
      fire(0);
      repeat (3) @(negedge clk);
      fire(4);
      wait_idle();
      check("R7 latched count", log_n, 4);
      check_sess(0, 0, 2, 8, 0, 0, "R9 normal restart");
      check_sess(2, 0, 2, 8, 0, 1, "R7 latched run");
      check("R7 irq twice", irq_a_cnt - ia, 2);
   endtask

   task automatic t_mask();
      log_n = 0; last_slot_a = 4'd12;
      fire(2); wait_idle();
      check("R5 masked count", log_n, 5);
      check_sess(0, 0, 5, 8, 0, 1, "R5 slots");
   endtask

   task automatic t_alt();
      int ia;
      log_n = 0; last_slot_a = 4'd0; alt_irq_a = 1;
      ia = irq_a_cnt;
      fire(0); wait_idle();
      check("R8 first silent", irq_a_cnt - ia, 0);
      fire(0); wait_idle();
      check("R8 second raises", irq_a_cnt - ia, 1);
      alt_irq_a = 0;
   endtask

   task automatic t_stop();
      log_n = 0; last_slot_a = 4'd2; stop_mode_a = 1;
      fire(0); wait_idle();
      fire(0); wait_idle();
      fire(0); wait_idle();
      check("R9 count", log_n, 9);
      check_sess(0, 0, 3, 8, 0, 0, "R9 run1");
      check_sess(3, 3, 3, 8, 0, 0, "R9 run2");
      check_sess(6, 6, 3, 8, 0, 1, "R9 wrap");
      @(negedge clk) ptr_clr_a = 1;
      @(negedge clk) ptr_clr_a = 0;
      log_n = 0;
      fire(0); wait_idle();
      check_sess(0, 0, 3, 8, 0, 1, "R10 ptr clear");
      stop_mode_a = 0;
      @(negedge clk) ptr_clr_a = 1;
      @(negedge clk) ptr_clr_a = 0;
   endtask

   task automatic t_cascade();
      int ia = irq_a_cnt;
      int ib = irq_b_cnt;
      cascade_en = 1; acq_len = 4'd0; exp_acq = 1;
      log_n = 0; last_slot_a = 4'd11;
      fire(4); wait_idle();
      check("R6 count12", log_n, 12);
      check_sess(0, 0, 12, 16, 0, 1, "R6 slots");
      log_n = 0; last_slot_a = 4'd15;
      fire(3); wait_idle();
      check("R6 count16", log_n, 16);
      check_sess(0, 0, 16, 16, 0, 1, "R6 full list");
      check("R6 irq_a", irq_a_cnt - ia, 2);
      check("R6 irq_b quiet", irq_b_cnt - ib, 0);
      cascade_en = 0;
   endtask

   initial begin
      for (int s = 0; s < 16; s++) slot_chan[s*4 +: 4] = 4'(chan_of(s));
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_dual_a();
      t_dual_b();
      t_both();
      t_latched();
      t_mask();
      t_alt();
      t_stop();
      t_cascade();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog got=running exp=idle");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule